// File: doc/BRIEF.md
# Chip-Select Port Pin Multiplexer

This block is an eight-pin general-purpose I/O port. Some of its pins can be taken over by other functions. Up to five low-numbered pins can carry chip-select strobes produced elsewhere in the chip. Three upper pins can carry bus-arbitration signals for an extra bus master. A two-bit strap is captured while reset is held, and it fixes how many pins become chip selects. Software can read the captured code back but cannot change it.

Each pin not claimed by an alternate function is a plain port pin. Its level comes from a data register and its driver enable comes from a direction register. A third register holds one bit per pin, which decides whether that pin's driver stays on while the chip is in power-down. The levels on the pads can always be read, whatever role a pin has.

There is no streaming data path in this block. Every interface is a plain control or status pin, and register accesses complete in a single cycle with no back-pressure.

Top module: `cs_port_mux`

## Requirements
- R1: While `rst_n` is low, each clock edge copies `strap_cfg` into the configuration code. After `rst_n` rises the code holds its value when the strap changes. Reading address 4 returns the code in bits 1:0, with bits 7:2 zero.
- R2: The configuration code sets how many pins are chip selects. Code 2'b10 gives none. Code 2'b01 gives pins 0–1, code 2'b00 gives pins 0–2 and code 2'b11 gives pins 0–4.
- R3: A pin that is a chip select has `pad_oe` high and `pad_out` equal to `cs_in` at the same index. Its data and direction bits have no effect on it.
- R4: A general-purpose pin drives `pad_out` from its data-register bit and `pad_oe` from its direction-register bit.
- R5: While `arb_en` is high, pin 5 is an input with `pad_oe` low, pin 6 outputs `hlda_in` and pin 7 outputs `breq_in`, and both of those have `pad_oe` high. While `arb_en` is low, pins 5–7 are general-purpose pins.
- R6: While `arb_en` is high, `hold_req` equals `pad_in[5]` delayed by two clock edges. While `arb_en` is low, `hold_req` is 0.
- R7: Reading address 3 returns `pad_in` at any time, whatever role each pin has.
- R8: While `pwr_down` is high, the `pad_oe` of each pin whose power-down keep bit is 0 is forced low. A pin whose keep bit is 1 keeps its normal enable.
- R9: After reset the data, direction and power-down keep registers are all 8'h00.
- R10: The writable registers are data at address 0, direction at address 1 and power-down keep at address 2, and each reads back at its own address. Writes to addresses 3 and 4 are ignored. Addresses 5–7 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; strap sampled while low |
| strap_cfg | input | 2 | Chip-select count strap |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data (combinational) |
| cs_in | input | 5 | Chip-select levels from the bus controller |
| hlda_in | input | 1 | Hold-acknowledge level to drive on pin 6 |
| breq_in | input | 1 | Bus-request level to drive on pin 7 |
| arb_en | input | 1 | Enables the arbitration roles on pins 5–7 |
| hold_req | output | 1 | Synchronized hold request from pin 5 |
| pwr_down | input | 1 | Power-down mode indicator |
| pad_in | input | 8 | Levels seen on the pads |
| pad_out | output | 8 | Levels driven to the pads |
| pad_oe | output | 8 | Pad driver enables |

## Verification
The hardest case to reach from the ports is the fixed chip-select count, because the strap is only sampled during reset. The stimulus table therefore carries the strap code in every row. The bench applies a fresh reset whenever the code changes, then moves the strap away from that value to show the captured code does not follow it. A second hard case is power-down acting on a pin whose enable is forced high as a chip select. The bench selects all five chip selects, clears the keep bits and raises `pwr_down` to check that the forced enable is still removed.

// File: rtl/cs_port_pkg.sv
package cs_port_pkg;

  localparam int CFG_W    = 2;
  localparam int ARB_NONE = 0;
  localparam int ARB_IN   = 1;
  localparam int ARB_OUT  = 2;

  typedef enum logic [1:0] {
    ROLE_GPIO,
    ROLE_CS,
    ROLE_ARB_IN,
    ROLE_ARB_OUT
  } pin_role_e;

  // Number of low pins handed to chip-select duty for a strap code.
  function automatic int cs_count(input logic [CFG_W-1:0] code);
    case (code)
      2'b10:   return 0;
      2'b01:   return 2;
      2'b00:   return 3;
      default: return 5;
    endcase
  endfunction

endpackage

// File: rtl/cs_strap_latch.sv
module cs_strap_latch #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] strap,
  output logic [W-1:0] code
);
  // Captured on every edge while reset is held, frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) code <= strap;
  end

  a_r1_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(code));
endmodule

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cs_pin_cell.sv
module cs_pin_cell
  import cs_port_pkg::*;
#(
  parameter bit CS_CAP   = 1'b0,
  parameter int ARB_KIND = ARB_NONE
) (
  input  logic cs_sel,
  input  logic arb_en,
  input  logic alt_val,
  input  logic gp_data,
  input  logic gp_dir,
  input  logic pwr_down,
  input  logic pd_keep,
  output logic pad_out,
  output logic pad_oe
);
  pin_role_e role;
  logic      oe_raw;

  always_comb begin
    if (CS_CAP && cs_sel)                       role = ROLE_CS;
    else if (ARB_KIND == ARB_IN  && arb_en)     role = ROLE_ARB_IN;
    else if (ARB_KIND == ARB_OUT && arb_en)     role = ROLE_ARB_OUT;
    else                                        role = ROLE_GPIO;
  end

  always_comb begin
    case (role)
      ROLE_CS:      begin pad_out = alt_val; oe_raw = 1'b1;   end
      ROLE_ARB_IN:  begin pad_out = 1'b0;    oe_raw = 1'b0;   end
      ROLE_ARB_OUT: begin pad_out = alt_val; oe_raw = 1'b1;   end
      default:      begin pad_out = gp_data; oe_raw = gp_dir; end
    endcase
  end

  // Power-down gating: keep bit 0 tri-states the driver.
  assign pad_oe = oe_raw & (~pwr_down | pd_keep);
endmodule

// File: rtl/cs_port_mux.sv
module cs_port_mux
  import cs_port_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int NUM_CS      = 5,
  parameter int ARB_BASE    = 5,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CFG_W-1:0]    strap_cfg,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_PINS-1:0] wr_data,
  output logic [NUM_PINS-1:0] rd_data,
  input  logic [NUM_CS-1:0]   cs_in,
  input  logic                hlda_in,
  input  logic                breq_in,
  input  logic                arb_en,
  output logic                hold_req,
  input  logic                pwr_down,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PDEN = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_PINS = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(4);

  logic [CFG_W-1:0]    cfg_q;
  logic [NUM_PINS-1:0] data_q, dir_q, pden_q;
  logic [NUM_PINS-1:0] cs_mask, alt_bit;
  logic                hold_sync;

  cs_strap_latch #(.W(CFG_W)) u_strap (
    .clk(clk), .rst_n(rst_n), .strap(strap_cfg), .code(cfg_q)
  );

  cs_sync #(.STAGES(SYNC_STAGES)) u_hold_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in[ARB_BASE]), .q(hold_sync)
  );
  assign hold_req = arb_en & hold_sync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      pden_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_DATA:  data_q <= wr_data;
        A_DIR:   dir_q  <= wr_data;
        A_PDEN:  pden_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_DATA:  rd_data = data_q;
      A_DIR:   rd_data = dir_q;
      A_PDEN:  rd_data = pden_q;
      A_PINS:  rd_data = pad_in;
      A_CFG:   rd_data = {{(NUM_PINS-CFG_W){1'b0}}, cfg_q};
      default: rd_data = '0;
    endcase
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam bit CS_CAP = (i < NUM_CS);
    localparam int KIND   = (i == ARB_BASE) ? ARB_IN :
                            ((i == ARB_BASE + 1) || (i == ARB_BASE + 2)) ? ARB_OUT :
                            ARB_NONE;

    assign cs_mask[i] = CS_CAP && (cs_count(cfg_q) > i);

    if (i < NUM_CS) begin : g_cs
      assign alt_bit[i] = cs_in[i];
    end else if (i == ARB_BASE + 1) begin : g_hlda
      assign alt_bit[i] = hlda_in;
    end else if (i == ARB_BASE + 2) begin : g_breq
      assign alt_bit[i] = breq_in;
    end else begin : g_none
      assign alt_bit[i] = 1'b0;
    end

    cs_pin_cell #(.CS_CAP(CS_CAP), .ARB_KIND(KIND)) u_cell (
      .cs_sel  (cs_mask[i]),
      .arb_en  (arb_en),
      .alt_val (alt_bit[i]),
      .gp_data (data_q[i]),
      .gp_dir  (dir_q[i]),
      .pwr_down(pwr_down),
      .pd_keep (pden_q[i]),
      .pad_out (pad_out[i]),
      .pad_oe  (pad_oe[i])
    );
  end

  a_r3_cs_enable_forced: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_down |-> ((pad_oe & cs_mask) == cs_mask));

  a_r8_pd_tristate: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> ((pad_oe & ~pden_q) == '0));

  a_r5_hold_pin_input: assert property (@(posedge clk) disable iff (!rst_n)
    arb_en |-> !pad_oe[ARB_BASE]);

  a_r6_hold_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_en |-> !hold_req);

  a_r10_cfg_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_CFG) |-> (rd_data[NUM_PINS-1:CFG_W] == '0));
endmodule

// File: tb/test_cs_port_mux.sv
`timescale 1ns/1ps
module test_cs_port_mux;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] strap_cfg = 2'b10;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [4:0] cs_in = '0;
  logic       hlda_in = 1'b0, breq_in = 1'b0, arb_en = 1'b0, pwr_down = 1'b0;
  logic       hold_req;
  logic [7:0] pad_in = '0, pad_out, pad_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cs_port_mux i_cs_port_mux (
    .clk(clk), .rst_n(rst_n), .strap_cfg(strap_cfg), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .cs_in(cs_in), .hlda_in(hlda_in),
    .breq_in(breq_in), .arb_en(arb_en), .hold_req(hold_req), .pwr_down(pwr_down),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // {cfg, data, dir, cs_in, expected pad_out, expected pad_oe}
  localparam logic [38:0] VEC [0:5] = '{
    {2'b10, 8'hA5, 8'hF0, 5'h1F, 8'hA5, 8'hF0},
    {2'b01, 8'h00, 8'h00, 5'h15, 8'h01, 8'h03},
    {2'b00, 8'hFF, 8'h00, 5'h00, 8'hF8, 8'h07},
    {2'b11, 8'hF0, 8'h0F, 5'h0A, 8'hEA, 8'h1F},
    {2'b11, 8'h00, 8'hFF, 5'h15, 8'h15, 8'hFF},
    {2'b10, 8'h3C, 8'hC3, 5'h00, 8'h3C, 8'hC3}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] code);
    @(negedge clk);
    rst_n = 1'b0; strap_cfg = code;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1; strap_cfg = ~code;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] cur_cfg;
    // R9: reset state
    do_reset(2'b10);
    cur_cfg = 2'b10;
    rd_check("R9 data reset", 3'd0, 8'h00);
    rd_check("R9 dir reset", 3'd1, 8'h00);
    rd_check("R9 pden reset", 3'd2, 8'h00);
    check("R9 oe after reset", pad_oe, 8'h00);

    // R1 R2 R3 R4: table walk
    for (int k = 0; k < 6; k++) begin
      logic [1:0] vcfg;
      vcfg = VEC[k][38:37];
      if (vcfg != cur_cfg || k == 0) begin
        do_reset(vcfg);
        cur_cfg = vcfg;
      end
      wr(3'd0, VEC[k][36:29]);
      wr(3'd1, VEC[k][28:21]);
      cs_in = VEC[k][20:16];
      @(negedge clk);
      check("R2 R3 R4 pad_out", pad_out, VEC[k][15:8]);
      check("R2 R3 R4 pad_oe", pad_oe, VEC[k][7:0]);
      rd_check("R1 strap held", 3'd4, {6'b0, vcfg});
    end

    // R10: readback and ignored writes
    wr(3'd2, 8'h5A);
    rd_check("R10 pden readback", 3'd2, 8'h5A);
    wr(3'd4, 8'hFF);
    rd_check("R10 cfg write ignored", 3'd4, {6'b0, cur_cfg});
    wr(3'd3, 8'hFF);
    rd_check("R10 data untouched", 3'd0, 8'h3C);
    rd_check("R10 unused address", 3'd6, 8'h00);

    // R7: pin read
    pad_in = 8'h96;
    rd_check("R7 pin read", 3'd3, 8'h96);
    pad_in = 8'h00;

    // R5: arbitration roles (cfg 10)
    wr(3'd0, 8'hFF);
    wr(3'd1, 8'hFF);
    hlda_in = 1'b1; breq_in = 1'b0; arb_en = 1'b1;
    #1;
    check("R5 arb oe", pad_oe, 8'hDF);
    check("R5 arb out", pad_out, 8'h5F);
    arb_en = 1'b0;
    #1;
    check("R5 arb off gpio out", pad_out, 8'hFF);

    // R6: two-edge synchronizer on pin 5
    arb_en = 1'b1;
    repeat (3) @(negedge clk);
    pad_in[5] = 1'b1;
    @(negedge clk);
    check("R6 hold after 1 edge", {7'b0, hold_req}, 8'h00);
    @(negedge clk);
    check("R6 hold after 2 edges", {7'b0, hold_req}, 8'h01);
    arb_en = 1'b0;
    #1;
    check("R6 hold gated", {7'b0, hold_req}, 8'h00);
    pad_in[5] = 1'b0;

    // R8: power-down gating on gpio pins
    wr(3'd2, 8'h0F);
    pwr_down = 1'b1;
    #1;
    check("R8 pd gpio", pad_oe, 8'h0F);
    pwr_down = 1'b0;

    // R8 with forced chip-select enables
    do_reset(2'b11);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h03);
    #1;
    check("R3 cs oe no pd", pad_oe, 8'h1F);
    pwr_down = 1'b1;
    #1;
    check("R8 pd cs pins", pad_oe, 8'h03);
    pwr_down = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule